// File: doc/BRIEF.md
# Secured Configuration Access Controller

This block sits in front of the configuration storage of a programmable logic array. It takes one command at a time over a valid/ready channel. Each command carries an opcode, an address and a data word. The commands write and read back configuration words, write and read bytes of a 64-bit user signature, force the macrocell registers through a test preload, set a one-way security lock, and run a full erase. Every accepted command returns one response beat. The beat carries read data plus two flags: one for a refused access and one for an unknown opcode.

While the lock is set, two operations are refused: configuration readback and register preload. The user signature stays readable and writable whatever the lock state. Only a full erase clears the lock. The erase also zeroes every configuration word and keeps the signature bytes. The storage is modelled as internal registers. The macrocell register states come out on a port so that the effect of a preload can be seen.

Top module: `cfg_access_ctrl`

## Requirements
- R1: While idle and out of reset, `cmd_ready` is high. After a command is accepted (`cmd_valid` and `cmd_ready` both high at a clock edge), the next cycle has `cmd_ready` low and `rsp_valid` high for exactly one cycle. In the cycle after that, `cmd_ready` is high again.
- R2: Opcode 0 writes `cmd_data` to the configuration word at `cmd_addr`. Opcode 1 returns that word on `rsp_data` while unlocked, with both flags low.
- R3: Opcode 2 writes `cmd_data[7:0]` to the signature byte selected by `cmd_addr[2:0]`. Opcode 3 returns that byte in `rsp_data[7:0]` with the upper bits zero. Both opcodes work with `rsp_denied` low whether or not the lock is set.
- R4: Opcode 5 sets the lock, and `secured` reads high from the response cycle on. The very next configuration read is refused: `rsp_data` is zero and `rsp_denied` is high.
- R5: Opcode 4 (preload) updates only the macrocell registers whose mask bit in `cmd_data[15:8]` is 1. Each such register takes the value of its bit in `cmd_data[7:0]`. Unmasked registers hold their state, and the response data is zero.
- R6: While locked, a preload leaves every macrocell register unchanged and responds with `rsp_denied` high.
- R7: Opcode 6 (erase) clears the lock and sets every configuration word to zero. The signature bytes keep their values.
- R8: Opcodes 7 to 15 respond with `rsp_error` high, `rsp_denied` low and zero data. They change neither the lock nor the macrocell registers.
- R9: After reset, `secured` is low, all macrocell registers and configuration words are zero, and `rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Controller can accept a command |
| cmd_op | input | 4 | Opcode |
| cmd_addr | input | ADDR_W (4) | Configuration word or signature byte address |
| cmd_data | input | DATA_W (32) | Write data or preload mask/value |
| rsp_valid | output | 1 | Response beat |
| rsp_data | output | DATA_W (32) | Read data, zero when not a permitted read |
| rsp_denied | output | 1 | Access refused by the lock |
| rsp_error | output | 1 | Unsupported opcode |
| secured | output | 1 | Lock state |
| cell_q | output | NUM_CELLS (8) | Macrocell register states |

## Verification
Configuration words are written with distinct patterns at the lowest and highest addresses and in the middle, then read back. This separates an address decode fault from a data path fault. Signature accesses use an address whose upper bits are set, which shows that only the low three bits select the byte. The same signature bytes are read again while locked and after an erase, which shows they are independent of the lock. Two preloads with disjoint masks and one preload while locked separate per-bit masking from a whole-register load and from a missing lock gate. Readback before the lock, just after it and after the erase shows when the lock takes effect and that the erase clears it.

// File: rtl/cfg_access_pkg.sv
package cfg_access_pkg;

  typedef enum logic [3:0] {
    OP_WR_CFG  = 4'd0,
    OP_RD_CFG  = 4'd1,
    OP_WR_SIG  = 4'd2,
    OP_RD_SIG  = 4'd3,
    OP_PRELOAD = 4'd4,
    OP_SET_SEC = 4'd5,
    OP_ERASE   = 4'd6
  } cac_op_e;

  typedef struct packed {
    logic wr_cfg;
    logic rd_cfg;
    logic wr_sig;
    logic rd_sig;
    logic preload;
    logic set_sec;
    logic erase;
    logic denied;
    logic error;
  } cac_strobe_t;

endpackage

// File: rtl/cac_decode.sv
module cac_decode
  import cfg_access_pkg::*;
(
  input  logic        go,
  input  logic [3:0]  op,
  input  logic        locked,
  output cac_strobe_t st
);
  always_comb begin
    st = '0;
    if (go) begin
      unique case (op)
        OP_WR_CFG:  st.wr_cfg  = 1'b1;
        OP_RD_CFG:  begin st.rd_cfg  = ~locked; st.denied = locked; end
        OP_WR_SIG:  st.wr_sig  = 1'b1;
        OP_RD_SIG:  st.rd_sig  = 1'b1;
        OP_PRELOAD: begin st.preload = ~locked; st.denied = locked; end
        OP_SET_SEC: st.set_sec = 1'b1;
        OP_ERASE:   st.erase   = 1'b1;
        default:    st.error   = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/cac_cfg_store.sv
module cac_cfg_store #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 32,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              clr,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] word_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    logic en;
    logic [DATA_W-1:0] word_d;
    always_comb begin
      en     = clr | (we & (addr == AW'(i)));
      word_d = clr ? '0 : wdata;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  word_q[i] <= '0;
      else if (en) word_q[i] <= word_d;
    end
  end

  assign rdata = word_q[addr];
endmodule

// File: rtl/cac_sig_store.sv
module cac_sig_store #(
  parameter int BYTES = 8,
  localparam int AW   = $clog2(BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] sel,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);
  logic [7:0] byte_q [BYTES];

  for (genvar i = 0; i < BYTES; i++) begin : g_byte
    logic en;
    assign en = we & (sel == AW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  byte_q[i] <= '0;
      else if (en) byte_q[i] <= wdata;
    end
  end

  assign rdata = byte_q[sel];
endmodule

// File: rtl/cac_cell_bank.sv
module cac_cell_bank #(
  parameter int CELLS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CELLS-1:0] mask,
  input  logic [CELLS-1:0] value,
  output logic [CELLS-1:0] q
);
  for (genvar i = 0; i < CELLS; i++) begin : g_cell
    logic en;
    assign en = load & mask[i];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q[i] <= 1'b0;
      else if (en) q[i] <= value[i];
    end
  end
endmodule

// File: rtl/cfg_access_ctrl.sv
module cfg_access_ctrl
  import cfg_access_pkg::*;
#(
  parameter int CFG_DEPTH = 16,
  parameter int DATA_W    = 32,
  parameter int SIG_BYTES = 8,
  parameter int NUM_CELLS = 8,
  localparam int ADDR_W   = $clog2(CFG_DEPTH),
  localparam int SIG_AW   = $clog2(SIG_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [3:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_data,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_denied,
  output logic              rsp_error,
  output logic              secured,
  output logic [NUM_CELLS-1:0] cell_q
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  logic        busy_q, busy_d;
  logic        sec_q, sec_d, sec_en;
  logic        go;
  cac_strobe_t st;
  logic [DATA_W-1:0] cfg_rdata;
  logic [7:0]        sig_rdata;
  logic [DATA_W-1:0] rdata_d;

  assign cmd_ready = rst_n_s & ~busy_q;
  assign go        = cmd_valid & cmd_ready;

  cac_decode u_dec (
    .go     (go),
    .op     (cmd_op),
    .locked (sec_q),
    .st     (st)
  );

  cac_cfg_store #(.DEPTH(CFG_DEPTH), .DATA_W(DATA_W)) u_cfg (
    .clk   (clk),
    .rst_n (rst_n_s),
    .we    (st.wr_cfg),
    .clr   (st.erase),
    .addr  (cmd_addr),
    .wdata (cmd_data),
    .rdata (cfg_rdata)
  );

  cac_sig_store #(.BYTES(SIG_BYTES)) u_sig (
    .clk   (clk),
    .rst_n (rst_n_s),
    .we    (st.wr_sig),
    .sel   (cmd_addr[SIG_AW-1:0]),
    .wdata (cmd_data[7:0]),
    .rdata (sig_rdata)
  );

  cac_cell_bank #(.CELLS(NUM_CELLS)) u_cells (
    .clk   (clk),
    .rst_n (rst_n_s),
    .load  (st.preload),
    .mask  (cmd_data[2*NUM_CELLS-1:NUM_CELLS]),
    .value (cmd_data[NUM_CELLS-1:0]),
    .q     (cell_q)
  );

  // next state
  always_comb begin
    busy_d = go;
    sec_en = st.set_sec | st.erase;
    sec_d  = st.set_sec;
    if (st.rd_cfg)      rdata_d = cfg_rdata;
    else if (st.rd_sig) rdata_d = {{(DATA_W-8){1'b0}}, sig_rdata};
    else                rdata_d = '0;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      busy_q     <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_data   <= '0;
      rsp_denied <= 1'b0;
      rsp_error  <= 1'b0;
    end else begin
      busy_q     <= busy_d;
      rsp_valid  <= go;
      rsp_data   <= rdata_d;
      rsp_denied <= st.denied;
      rsp_error  <= st.error;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)    sec_q <= 1'b0;
    else if (sec_en) sec_q <= sec_d;
  end

  assign secured = sec_q;
endmodule

// File: rtl/cfg_access_ctrl_chk.sv
module cfg_access_ctrl_chk
  import cfg_access_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 32,
  parameter int NUM_CELLS = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [3:0]        cmd_op,
  input logic [DATA_W-1:0] rsp_data,
  input logic              rsp_valid,
  input logic              rsp_denied,
  input logic              rsp_error,
  input logic              secured,
  input logic [NUM_CELLS-1:0] cell_q
);
  logic acc;
  assign acc = cmd_valid & cmd_ready;

  a_r1_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> (!cmd_ready && rsp_valid));
  a_r1_single_beat: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (cmd_ready && !rsp_valid));
  a_r3_sig_never_denied: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (cmd_op == OP_RD_SIG || cmd_op == OP_WR_SIG)) |=> !rsp_denied);
  a_r4_lock_now: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_op == OP_SET_SEC) |=> secured);
  a_r4_denied_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_denied |-> (rsp_data == '0));
  a_r6_locked_preload: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_op == OP_PRELOAD && secured) |=> ($stable(cell_q) && rsp_denied));
  a_r7_erase_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_op == OP_ERASE) |=> !secured);
  a_r8_bad_op: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_op > 4'd6) |=> (rsp_error && !rsp_denied && rsp_data == '0
                                && $stable(secured) && $stable(cell_q)));
endmodule

bind cfg_access_ctrl cfg_access_ctrl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_CELLS(NUM_CELLS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_op(cmd_op), .rsp_data(rsp_data), .rsp_valid(rsp_valid),
  .rsp_denied(rsp_denied), .rsp_error(rsp_error), .secured(secured),
  .cell_q(cell_q)
);

// File: tb/tb_cfg_access_ctrl.sv
module tb_cfg_access_ctrl;
  localparam int AW = 4;
  localparam int DW = 32;
  localparam int NC = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic [3:0] cmd_op = '0;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] cmd_data = '0;
  logic rsp_valid, rsp_denied, rsp_error, secured;
  logic [DW-1:0] rsp_data;
  logic [NC-1:0] cell_q;

  int checks = 0;
  int fails = 0;

  typedef struct {
    logic [DW-1:0] data;
    logic          den;
    logic          err;
    string         tag;
  } exp_t;
  exp_t q[$];

  // requirement-level model
  logic [DW-1:0] m_cfg [16];
  logic [7:0]    m_sig [8];
  logic [NC-1:0] m_cells;
  logic          m_sec;

  always #2.5 clk = ~clk;

  cfg_access_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_denied(rsp_denied),
    .rsp_error(rsp_error), .secured(secured), .cell_q(cell_q)
  );

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: compares each response beat with the queue head
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      exp_t e;
      if (q.size() == 0) begin
        chk(1'b0, "R1 unexpected response", 32'd1, 32'd0);
      end else begin
        e = q.pop_front();
        chk(rsp_data == e.data, {e.tag, " data"}, rsp_data, e.data);
        chk(rsp_denied == e.den && rsp_error == e.err, {e.tag, " flags"},
            {30'd0, rsp_denied, rsp_error}, {30'd0, e.den, e.err});
        chk(cmd_ready == 1'b0, "R1 ready low in response cycle",
            {31'd0, cmd_ready}, 32'd0);
      end
    end
  end

  // driver: predicts and pushes, then issues one command
  task automatic do_cmd(input logic [3:0] op, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, input string tag);
    exp_t e;
    e.data = '0; e.den = 1'b0; e.err = 1'b0; e.tag = tag;
    case (op)
      4'd0: m_cfg[a] = d;
      4'd1: if (m_sec) e.den = 1'b1; else e.data = m_cfg[a];
      4'd2: m_sig[a[2:0]] = d[7:0];
      4'd3: e.data = {24'd0, m_sig[a[2:0]]};
      4'd4: if (m_sec) e.den = 1'b1;
            else m_cells = (m_cells & ~d[15:8]) | (d[7:0] & d[15:8]);
      4'd5: m_sec = 1'b1;
      4'd6: begin m_sec = 1'b0; for (int i = 0; i < 16; i++) m_cfg[i] = '0; end
      default: e.err = 1'b1;
    endcase
    q.push_back(e);
    @(negedge clk);
    chk(cmd_ready == 1'b1, "R1 ready while idle", {31'd0, cmd_ready}, 32'd1);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(cell_q == m_cells, {tag, " cells"}, {24'd0, cell_q}, {24'd0, m_cells});
    chk(secured == m_sec, {tag, " lock"}, {31'd0, secured}, {31'd0, m_sec});
  endtask

  initial begin
    for (int i = 0; i < 16; i++) m_cfg[i] = '0;
    for (int i = 0; i < 8; i++) m_sig[i] = '0;
    m_cells = '0; m_sec = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(rsp_valid == 1'b0 && secured == 1'b0 && cell_q == '0, "R9 reset state",
        {22'd0, rsp_valid, secured, cell_q}, 32'd0);
    chk(cmd_ready == 1'b1, "R9 ready after reset", {31'd0, cmd_ready}, 32'd1);
    do_cmd(4'd1, 4'd3, '0, "R9 cfg cleared");
    // R2 write and read back
    do_cmd(4'd0, 4'd3, 32'hA5A5_0001, "R2 wr");
    do_cmd(4'd0, 4'd15, 32'hFFFF_FFFF, "R2 wr");
    do_cmd(4'd0, 4'd0, 32'h0000_1234, "R2 wr");
    do_cmd(4'd1, 4'd3, '0, "R2 rd mid");
    do_cmd(4'd1, 4'd15, '0, "R2 rd top");
    do_cmd(4'd1, 4'd0, '0, "R2 rd bottom");
    // R3 signature bytes, upper address bits ignored
    do_cmd(4'd2, 4'd0, 32'hFFFF_FF11, "R3 wr");
    do_cmd(4'd2, 4'd7, 32'h0000_00EE, "R3 wr");
    do_cmd(4'd2, 4'd9, 32'h0000_0042, "R3 wr alias");
    do_cmd(4'd3, 4'd1, '0, "R3 rd");
    do_cmd(4'd3, 4'd0, '0, "R3 rd");
    do_cmd(4'd3, 4'd15, '0, "R3 rd");
    // R5 masked preload
    do_cmd(4'd4, 4'd0, 32'h0000_0F05, "R5 low nibble");
    do_cmd(4'd4, 4'd0, 32'h0000_F0FF, "R5 high nibble");
    do_cmd(4'd4, 4'd0, 32'h0000_0000, "R5 empty mask");
    // R8 unsupported opcodes
    do_cmd(4'd7, 4'd0, 32'h0000_FF00, "R8 op7");
    do_cmd(4'd15, 4'd3, 32'h0000_FFFF, "R8 op15");
    // R4 lock, immediate effect
    do_cmd(4'd5, 4'd0, '0, "R4 set");
    do_cmd(4'd1, 4'd3, '0, "R4 rd refused");
    do_cmd(4'd3, 4'd7, '0, "R3 rd locked");
    do_cmd(4'd2, 4'd2, 32'h0000_0077, "R3 wr locked");
    do_cmd(4'd3, 4'd2, '0, "R3 rd locked");
    // R6 preload refused
    do_cmd(4'd4, 4'd0, 32'h0000_FF00, "R6 preload locked");
    // R7 erase
    do_cmd(4'd6, 4'd0, '0, "R7 erase");
    do_cmd(4'd1, 4'd3, '0, "R7 cfg zero");
    do_cmd(4'd1, 4'd15, '0, "R7 cfg zero");
    do_cmd(4'd3, 4'd7, '0, "R7 sig kept");
    do_cmd(4'd4, 4'd0, 32'h0000_FF3C, "R7 preload again");
    repeat (3) @(negedge clk);
    chk(q.size() == 0, "R1 responses outstanding", q.size(), 32'd0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++; checks++;
    $display("FAIL R1 watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule